// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block sits between a byte-wide host bus and the working parts of a 16550-style serial port. Each access carries a 3-bit offset, a read or write strobe and a data byte. The block decodes the access and sends it to the right place. It stores the control bytes itself: the interrupt enable, line control, modem control and scratch registers, plus the 16-bit baud divisor. Receive data, the interrupt identification code and the line and modem status bytes come from neighbouring logic, and the block only passes them through to the bus.

Bit 7 of the line control register is the bank-select bit. When it is set, offsets 0 and 1 reach the two divisor bytes. When it is clear, they reach the data path and the interrupt enable register. Offset 2 splits by direction: a read returns the identification code and a write produces a FIFO-control strobe. A read of the receive buffer raises a pop strobe to the receiver. A write of the transmit buffer raises a load strobe to the transmitter. Both strobes share one write-data output with the FIFO-control strobe.

Top module: `sio_regbank`

## Requirements
- R1: After a synchronous reset, the line control, interrupt enable, modem control and scratch registers read 0 and the divisor is 0x0001.
- R2: The bank-select bit is bit 7 of the line control register, which is written and read at offset 3 in either bank.
- R3: With bank bit 0, a read of offset 0 returns `rx_data` and asserts `rx_pop` in that cycle. A write of offset 0 asserts `tx_load` in that cycle, with the byte on `strobe_data`.
- R4: With bank bit 0, offset 1 writes and reads the interrupt enable register.
- R5: With bank bit 1, offset 0 is the divisor low byte and offset 1 is the divisor high byte, both readable. Such accesses raise neither `rx_pop` nor `tx_load` and leave the interrupt enable register unchanged.
- R6: In either bank, a read of offset 2 returns `intr_id`, and a write of offset 2 asserts `fifo_ctl_wr` in that cycle with the byte on `strobe_data`.
- R7: Offset 4 stores the modem control byte and offset 7 stores the scratch byte, both read back as written. Reads of offsets 5 and 6 return `line_stat` and `modem_stat`.
- R8: Writes to offsets 5 and 6 change no stored register and raise no strobe.
- R9: The divisor stays within 1..65535. A divisor byte write that would make the whole value 0 is discarded.
- R10: `bus_rdata` is 0 in any cycle where `bus_rd` is low. Read data is valid in the same cycle as `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| rx_data | input | 8 | Head byte of the receive path |
| intr_id | input | 8 | Interrupt identification code |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| rx_pop | output | 1 | Receive buffer read strobe |
| tx_load | output | 1 | Transmit holding register load strobe |
| fifo_ctl_wr | output | 1 | FIFO control write strobe |
| strobe_data | output | 8 | Byte that goes with `tx_load` and `fifo_ctl_wr` |
| ier_q | output | 8 | Interrupt enable register |
| lcr_q | output | 8 | Line control register |
| mcr_q | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor |

## Verification
Each offset is driven with the bank bit clear and then set. This separates the data path and interrupt enable register from the two divisor bytes. It also shows that offsets 2 through 7 do not depend on the bank bit. Distinct byte values on the pass-through inputs show which source a read actually selected. Strobes are captured inside the access cycle, so a pop or load that fires in the wrong bank is seen. Divisor writes that would reach zero are checked against a sequence that reaches a legal value with one byte at 0x00.

// File: rtl/sio_regbank_pkg.sv
package sio_regbank_pkg;

    localparam int DW      = 8;
    localparam int AW      = 3;
    localparam int DIVW    = 2 * DW;
    localparam int BANK_BIT = 7;

    localparam logic [AW-1:0] OFS_DATA  = 3'd0;
    localparam logic [AW-1:0] OFS_IEN   = 3'd1;
    localparam logic [AW-1:0] OFS_IDFC  = 3'd2;
    localparam logic [AW-1:0] OFS_LCTL  = 3'd3;
    localparam logic [AW-1:0] OFS_MCTL  = 3'd4;
    localparam logic [AW-1:0] OFS_LSTAT = 3'd5;
    localparam logic [AW-1:0] OFS_MSTAT = 3'd6;
    localparam logic [AW-1:0] OFS_SCR   = 3'd7;

    // Plain byte registers held in the store, by index
    localparam int NPLAIN  = 4;
    localparam int PL_IEN  = 0;
    localparam int PL_LCTL = 1;
    localparam int PL_MCTL = 2;
    localparam int PL_SCR  = 3;

    typedef struct packed {
        logic [NPLAIN-1:0] plain_we;
        logic              div_lo_we;
        logic              div_hi_we;
        logic              rx_pop;
        logic              tx_load;
        logic              fifo_wr;
    } acc_sel_t;

    function automatic logic div_legal(input logic [DIVW-1:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
    import sio_regbank_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          bank,
    output acc_sel_t      sel
);
    always_comb begin
        sel = '0;
        if (wr) begin
            case (addr)
                OFS_DATA: begin
                    if (bank) sel.div_lo_we = 1'b1;
                    else      sel.tx_load   = 1'b1;
                end
                OFS_IEN: begin
                    if (bank) sel.div_hi_we        = 1'b1;
                    else      sel.plain_we[PL_IEN] = 1'b1;
                end
                OFS_IDFC: sel.fifo_wr            = 1'b1;
                OFS_LCTL: sel.plain_we[PL_LCTL]  = 1'b1;
                OFS_MCTL: sel.plain_we[PL_MCTL]  = 1'b1;
                OFS_SCR:  sel.plain_we[PL_SCR]   = 1'b1;
                default:  ;
            endcase
        end
        if (rd && addr == OFS_DATA && !bank)
            sel.rx_pop = 1'b1;
    end
endmodule

// File: rtl/sio_ctl_store.sv
module sio_ctl_store
    import sio_regbank_pkg::*;
#(
    parameter logic [DIVW-1:0] DIV_RESET = 16'd1
)(
    input  logic                       clk,
    input  logic                       rst,
    input  acc_sel_t                   sel,
    input  logic [DW-1:0]              wdata,
    output logic [NPLAIN-1:0][DW-1:0]  plain_q,
    output logic [DIVW-1:0]            div_q
);
    logic [DW-1:0]   regs [NPLAIN];
    logic [DIVW-1:0] div_next;

    for (genvar gi = 0; gi < NPLAIN; gi++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                regs[gi] <= '0;
            else if (sel.plain_we[gi])
                regs[gi] <= wdata;
        end
        assign plain_q[gi] = regs[gi];
    end

    always_comb begin
        div_next = div_q;
        if (sel.div_lo_we) div_next[DW-1:0]    = wdata;
        if (sel.div_hi_we) div_next[DIVW-1:DW] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= DIV_RESET;
        else if ((sel.div_lo_we || sel.div_hi_we) && div_legal(div_next))
            div_q <= div_next;
    end
endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
    import sio_regbank_pkg::*;
(
    input  logic                      rd,
    input  logic [AW-1:0]             addr,
    input  logic                      bank,
    input  logic [DW-1:0]             rx_data,
    input  logic [DW-1:0]             intr_id,
    input  logic [DW-1:0]             line_stat,
    input  logic [DW-1:0]             modem_stat,
    input  logic [NPLAIN-1:0][DW-1:0] plain_q,
    input  logic [DIVW-1:0]           div_q,
    output logic [DW-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                OFS_DATA:  rdata = bank ? div_q[DW-1:0]    : rx_data;
                OFS_IEN:   rdata = bank ? div_q[DIVW-1:DW] : plain_q[PL_IEN];
                OFS_IDFC:  rdata = intr_id;
                OFS_LCTL:  rdata = plain_q[PL_LCTL];
                OFS_MCTL:  rdata = plain_q[PL_MCTL];
                OFS_LSTAT: rdata = line_stat;
                OFS_MSTAT: rdata = modem_stat;
                default:   rdata = plain_q[PL_SCR];
            endcase
        end
    end
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_regbank_pkg::*;
#(
    parameter logic [DIVW-1:0] DIV_RESET = 16'd1
)(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [DW-1:0]   rx_data,
    input  logic [DW-1:0]   intr_id,
    input  logic [DW-1:0]   line_stat,
    input  logic [DW-1:0]   modem_stat,
    output logic            rx_pop,
    output logic            tx_load,
    output logic            fifo_ctl_wr,
    output logic [DW-1:0]   strobe_data,
    output logic [DW-1:0]   ier_q,
    output logic [DW-1:0]   lcr_q,
    output logic [DW-1:0]   mcr_q,
    output logic [DIVW-1:0] divisor
);
    acc_sel_t                  sel;
    logic [NPLAIN-1:0][DW-1:0] plain_q;
    logic                      bank;

    assign bank = plain_q[PL_LCTL][BANK_BIT];

    sio_addr_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .bank (bank),
        .sel  (sel)
    );

    sio_ctl_store #(.DIV_RESET(DIV_RESET)) u_store (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .wdata   (bus_wdata),
        .plain_q (plain_q),
        .div_q   (divisor)
    );

    sio_read_mux u_rmux (
        .rd         (bus_rd),
        .addr       (bus_addr),
        .bank       (bank),
        .rx_data    (rx_data),
        .intr_id    (intr_id),
        .line_stat  (line_stat),
        .modem_stat (modem_stat),
        .plain_q    (plain_q),
        .div_q      (divisor),
        .rdata      (bus_rdata)
    );

    assign rx_pop      = sel.rx_pop;
    assign tx_load     = sel.tx_load;
    assign fifo_ctl_wr = sel.fifo_wr;
    assign strobe_data = bus_wdata;
    assign ier_q       = plain_q[PL_IEN];
    assign lcr_q       = plain_q[PL_LCTL];
    assign mcr_q       = plain_q[PL_MCTL];
endmodule

// File: rtl/sio_regbank_chk.sv
module sio_regbank_chk
    import sio_regbank_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            rx_pop,
    input logic            tx_load,
    input logic            fifo_ctl_wr,
    input logic [DW-1:0]   ier_q,
    input logic [DW-1:0]   lcr_q,
    input logic [DW-1:0]   mcr_q,
    input logic [DIVW-1:0] divisor
);
    p_lcr_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LCTL) |=> lcr_q == $past(bus_wdata));

    p_pop_gate_r3: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (bus_rd && !lcr_q[BANK_BIT]));

    p_ier_write_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_IEN && !lcr_q[BANK_BIT]) |=> ier_q == $past(bus_wdata));

    p_bank1_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        lcr_q[BANK_BIT] |-> (!rx_pop && !tx_load));

    p_div_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !lcr_q[BANK_BIT] |=> $stable(divisor));

    p_fifo_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_IDFC) |-> fifo_ctl_wr);

    p_status_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == OFS_LSTAT || bus_addr == OFS_MSTAT))
        |=> ($stable(lcr_q) && $stable(ier_q) && $stable(mcr_q) && $stable(divisor)));

    p_div_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        divisor != '0);

    p_idle_rdata_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);
endmodule

bind sio_regbank sio_regbank_chk u_chk (.*);

// File: tb/sio_regbank_tb.sv
module sio_regbank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic [7:0]  rx_data = 8'hA1, intr_id = 8'hC2, line_stat = 8'h63, modem_stat = 8'hB4;
    logic        rx_pop, tx_load, fifo_ctl_wr;
    logic [7:0]  strobe_data, ier_q, lcr_q, mcr_q;
    logic [15:0] divisor;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    sio_regbank u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // strobes captured inside the access cycle: {rx_pop, tx_load, fifo_ctl_wr}
    task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic [2:0] st, output logic [7:0] sd);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #2;
        st = {rx_pop, tx_load, fifo_ctl_wr};
        sd = strobe_data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [2:0] st);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        d = bus_rdata;
        st = {rx_pop, tx_load, fifo_ctl_wr};
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic [2:0] st;
        chk("R1 lcr", lcr_q, 0);
        chk("R1 ier", ier_q, 0);
        chk("R1 mcr", mcr_q, 0);
        chk("R1 divisor", divisor, 16'h0001);
        rd(3'd7, d, st); chk("R1 scratch", d, 0);
    endtask

    task automatic t_data_bank0;
        logic [7:0] d, sd; logic [2:0] st;
        rd(3'd0, d, st);
        chk("R3 rx read", d, 8'hA1);
        chk("R3 pop strobe", st, 3'b100);
        wr(3'd0, 8'h5E, st, sd);
        chk("R3 load strobe", st, 3'b010);
        chk("R3 load byte", sd, 8'h5E);
        chk("R3 ier untouched", ier_q, 0);
    endtask

    task automatic t_ier;
        logic [7:0] d, sd; logic [2:0] st;
        wr(3'd1, 8'h0D, st, sd);
        chk("R4 ier port", ier_q, 8'h0D);
        rd(3'd1, d, st); chk("R4 ier read", d, 8'h0D);
        wr(3'd3, 8'h1B, st, sd);
        rd(3'd3, d, st); chk("R2 lcr read", d, 8'h1B);
    endtask

    task automatic t_divisor;
        logic [7:0] d, sd; logic [2:0] st;
        wr(3'd3, 8'h83, st, sd);
        chk("R2 bank bit set", lcr_q[7], 1'b1);
        wr(3'd0, 8'h34, st, sd); chk("R5 no strobe wr0", st, 3'b000);
        wr(3'd1, 8'h12, st, sd); chk("R5 no strobe wr1", st, 3'b000);
        chk("R5 divisor", divisor, 16'h1234);
        chk("R5 ier kept", ier_q, 8'h0D);
        rd(3'd0, d, st); chk("R5 low read", d, 8'h34); chk("R5 no pop", st, 3'b000);
        rd(3'd1, d, st); chk("R5 high read", d, 8'h12);
        rd(3'd3, d, st); chk("R2 lcr read bank1", d, 8'h83);
    endtask

    task automatic t_offset2(input string tag);
        logic [7:0] d, sd; logic [2:0] st;
        rd(3'd2, d, st); chk({tag, " iid read"}, d, 8'hC2);
        wr(3'd2, 8'hC7, st, sd);
        chk({tag, " fifo strobe"}, st, 3'b001);
        chk({tag, " fifo byte"}, sd, 8'hC7);
    endtask

    task automatic t_misc;
        logic [7:0] d, sd; logic [2:0] st;
        wr(3'd4, 8'h13, st, sd); chk("R7 mcr port", mcr_q, 8'h13);
        rd(3'd4, d, st); chk("R7 mcr read", d, 8'h13);
        wr(3'd7, 8'hE9, st, sd);
        rd(3'd7, d, st); chk("R7 scratch read", d, 8'hE9);
        rd(3'd5, d, st); chk("R7 line status", d, 8'h63);
        rd(3'd6, d, st); chk("R7 modem status", d, 8'hB4);
    endtask

    task automatic t_status_wr;
        logic [7:0] d, sd; logic [2:0] st;
        logic [15:0] dv; logic [7:0] l, i, m;
        dv = divisor; l = lcr_q; i = ier_q; m = mcr_q;
        wr(3'd5, 8'hFF, st, sd); chk("R8 no strobe 5", st, 3'b000);
        wr(3'd6, 8'h00, st, sd); chk("R8 no strobe 6", st, 3'b000);
        chk("R8 lcr", lcr_q, l); chk("R8 ier", ier_q, i);
        chk("R8 mcr", mcr_q, m); chk("R8 divisor", divisor, dv);
        rd(3'd7, d, st); chk("R8 scratch", d, 8'hE9);
        rd(3'd5, d, st); chk("R8 status passthru", d, 8'h63);
    endtask

    task automatic t_div_zero;
        logic [7:0] sd; logic [2:0] st;
        wr(3'd3, 8'h80, st, sd);
        wr(3'd1, 8'h00, st, sd); chk("R9 0x0034 legal", divisor, 16'h0034);
        wr(3'd0, 8'h00, st, sd); chk("R9 zero rejected", divisor, 16'h0034);
        wr(3'd0, 8'h01, st, sd); chk("R9 min divisor", divisor, 16'h0001);
        wr(3'd1, 8'hFF, st, sd); wr(3'd0, 8'hFF, st, sd);
        chk("R9 max divisor", divisor, 16'hFFFF);
        wr(3'd3, 8'h03, st, sd);
    endtask

    task automatic t_idle;
        @(negedge clk);
        bus_addr = 3'd5;
        #2 chk("R10 idle rdata", bus_rdata, 0);
        bus_addr = 3'd0;
        #1 chk("R10 idle no pop", rx_pop, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_data_bank0();
        t_ier();
        t_offset2("R6 bank0");
        t_divisor();
        t_offset2("R6 bank1");
        t_misc();
        t_status_wr();
        t_div_zero();
        rx_data = 8'h3C;
        t_idle();
        begin
            logic [7:0] d; logic [2:0] st;
            rd(3'd0, d, st); chk("R3 rx read new byte", d, 8'h3C);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule